// File: doc/BRIEF.md
# ADC Trigger and Result Controller

This block is the digital sequencer that sits beside a 12-bit successive-approximation converter core. It chooses what launches a conversion (a software go bit, a timer overflow pulse, a baud-rate generator overflow pulse, or continuous free-running operation). It issues a one-cycle start pulse to the converter core and tracks the busy period until the core reports completion. It then captures the 12-bit code and presents it as a high/low byte pair, left- or right-justified.

Software reaches the block through a byte-wide register bus with four addresses. Two sticky flags record events: one for conversion completion and one for sample-and-hold completion. Software clears each flag by writing 0 to it. The sample-and-hold flag drives an interrupt request when its enable bit is set.

Every pin is plain. The core-side signals `conv_sampled` and `conv_done` are single-cycle pulses with no ready. The result register always accepts a completed code, so there is never back-pressure. Bus writes take effect in one cycle, and reads are combinational from `bus_addr`.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, all four addresses read 0x00, and `conv_start` and `smp_irq` are 0.
- R2: The control register is at address 0, with bits [1:0] = trigger mode, bit 2 = justify, bit 3 = go and bit 4 = interrupt enable. In mode 00, writing go=1 while idle makes `conv_start` pulse in the following cycle. Go reads 1 until that conversion completes, then reads 0.
- R3: In mode 01 a `tmr_ovf` pulse while idle asserts `conv_start` in the same cycle, and `brg_ovf` is ignored. In mode 11 a `brg_ovf` pulse does this, and `tmr_ovf` is ignored.
- R4: In mode 10 a conversion starts whenever the block is idle, which includes the cycle right after each completion. This continues until the mode is changed.
- R5: While busy, no trigger of any kind (timer, baud, a go write) causes `conv_start`. A go write made while busy is dropped and does not set go.
- R6: The status register is at address 1, with bit 0 = done flag, bit 1 = sample flag and bit 2 = busy. A `conv_done` pulse while busy does all of the following at one clock edge: captures `conv_code`, sets the done flag, clears go and clears busy. A `conv_done` pulse while idle changes nothing.
- R7: With justify=0, address 2 reads code[11:4], and address 3 reads {code[3:0], 4'b0000}.
- R8: With justify=1, address 2 reads {4'b0000, code[11:8]}, and address 3 reads code[7:0]. Justify applies to the stored code when it is read.
- R9: A `conv_sampled` pulse while busy sets the sample flag. Writing address 1 with bit 1 = 0 clears it. Writing bit 1 = 1 leaves it unchanged.
- R10: If a flag's hardware set and its software clear fall in the same cycle, the flag ends up set.
- R11: `smp_irq` is high exactly when the sample flag and the interrupt enable are both 1.
- R12: Writing address 1 with bit 0 = 0 clears the done flag. Writing bit 0 = 1 leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address (0 control, 1 status, 2 result high, 3 result low) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| tmr_ovf | input | 1 | Timer overflow pulse (trigger source for mode 01) |
| brg_ovf | input | 1 | Baud-rate generator overflow pulse (trigger source for mode 11) |
| conv_start | output | 1 | One-cycle start pulse to the converter core |
| conv_sampled | input | 1 | Core pulse: sampling of the channel finished |
| conv_done | input | 1 | Core pulse: conversion finished, `conv_code` valid |
| conv_code | input | 12 | Conversion result from the core |
| smp_irq | output | 1 | Sample-and-hold interrupt request |

## Verification
The hardest cases to reach are the same-cycle collisions. In one, a hardware flag set coincides with a software clear. In the other, a conversion completes in the same cycle that free-running mode is switched off. The bench plays the converter core itself, cycle by cycle, so it can place `conv_sampled` or `conv_done` in exactly the cycle of a status or control write. A behavioural model predicts `conv_start`, `smp_irq` and the read data on every clock, so a lost set or a stray restart shows up at once.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [1:0] {
    TRIG_SOFT = 2'd0,
    TRIG_TMR  = 2'd1,
    TRIG_FREE = 2'd2,
    TRIG_BRG  = 2'd3
  } trig_mode_e;

  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] A_STAT = 2'd1;
  localparam logic [ADDR_W-1:0] A_RHI  = 2'd2;
  localparam logic [ADDR_W-1:0] A_RLO  = 2'd3;

  // control register field positions
  localparam int C_JUST = 2;
  localparam int C_GO   = 3;
  localparam int C_IE   = 4;
  // status register field positions
  localparam int S_DONE = 0;
  localparam int S_SMP  = 1;
  localparam int S_BUSY = 2;

  localparam int N_FLAGS = 2;
  localparam int F_DONE  = 0;
  localparam int F_SMP   = 1;
endpackage

// File: rtl/adc_trig_sel.sv
module adc_trig_sel
  import adc_seq_pkg::*;
(
  input  trig_mode_e mode,
  input  logic       go,
  input  logic       tmr_ovf,
  input  logic       brg_ovf,
  input  logic       busy,
  output logic       launch
);
  logic req;

  always_comb begin
    unique case (mode)
      TRIG_SOFT: req = go;
      TRIG_TMR:  req = tmr_ovf;
      TRIG_FREE: req = 1'b1;
      TRIG_BRG:  req = brg_ovf;
      default:   req = 1'b0;
    endcase
    launch = req && !busy;
  end
endmodule

// File: rtl/adc_conv_fsm.sv
module adc_conv_fsm #(
  parameter int CODE_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  logic              go_set_req,
  input  logic              conv_done,
  input  logic [CODE_W-1:0] conv_code,
  output logic              busy,
  output logic              go,
  output logic [CODE_W-1:0] code_q,
  output logic              done_evt
);
  assign done_evt = conv_done && busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      go     <= 1'b0;
      code_q <= '0;
    end else begin
      if (done_evt) begin
        busy   <= 1'b0;
        go     <= 1'b0;
        code_q <= conv_code;
      end else begin
        if (launch)
          busy <= 1'b1;
        if (go_set_req && !busy)
          go <= 1'b1;
      end
    end
  end

  // R2: a launch always leads to a busy period
  p_busy_after_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> busy);
  // R6: completion captures the code and frees the block in one edge
  p_capture_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && busy) |=> (!busy && !go && code_q == $past(conv_code)));
  // R6: a done pulse while idle leaves the result alone
  p_idle_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && !busy) |=> $stable(code_q));
  // R5: a go request while busy does not set go
  p_go_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !go && go_set_req) |=> !go);
endmodule

// File: rtl/adc_sticky_flag.sv
module adc_sticky_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic q
);
  always_ff @(posedge clk) begin
    if (!rst_n)
      q <= 1'b0;
    else if (set)
      q <= 1'b1;
    else if (clr)
      q <= 1'b0;
  end

  // R10: set beats a simultaneous clear
  p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> q);
  // R9: a lone clear empties the flag
  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set) |=> !q);
  // R12: without set or clear the flag holds
  p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !set) |=> $stable(q));
endmodule

// File: rtl/adc_reg_if.sv
module adc_reg_if
  import adc_seq_pkg::*;
#(
  parameter int CODE_W = 12,
  parameter int REG_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  input  logic              go,
  input  logic              busy,
  input  logic              done_q,
  input  logic              smp_q,
  input  logic [CODE_W-1:0] code_q,
  output trig_mode_e        mode,
  output logic              just,
  output logic              ie,
  output logic              go_set_req,
  output logic              clr_done,
  output logic              clr_smp,
  output logic [REG_W-1:0]  bus_rdata
);
  localparam int FMT_W = 2 * REG_W;
  localparam int PAD_W = FMT_W - CODE_W;

  logic wr_ctrl, wr_stat;
  logic [FMT_W-1:0] res_fmt;
  logic unused_wbits;

  assign wr_ctrl = bus_wr && (bus_addr == A_CTRL);
  assign wr_stat = bus_wr && (bus_addr == A_STAT);
  assign unused_wbits = ^bus_wdata[REG_W-1:C_IE+1];

  assign go_set_req = wr_ctrl && bus_wdata[C_GO];
  assign clr_done   = wr_stat && !bus_wdata[S_DONE];
  assign clr_smp    = wr_stat && !bus_wdata[S_SMP];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode <= TRIG_SOFT;
      just <= 1'b0;
      ie   <= 1'b0;
    end else if (wr_ctrl) begin
      mode <= trig_mode_e'(bus_wdata[1:0]);
      just <= bus_wdata[C_JUST];
      ie   <= bus_wdata[C_IE];
    end
  end

  // justification: right puts the code at the bottom, left at the top
  generate
    if (PAD_W > 0) begin : g_pad
      always_comb
        res_fmt = just ? {{PAD_W{1'b0}}, code_q} : {code_q, {PAD_W{1'b0}}};
    end else begin : g_nopad
      always_comb res_fmt = code_q;
    end
  endgenerate

  always_comb begin
    unique case (bus_addr)
      A_CTRL:  bus_rdata = REG_W'({ie, go, just, mode});
      A_STAT:  bus_rdata = REG_W'({busy, smp_q, done_q});
      A_RHI:   bus_rdata = res_fmt[FMT_W-1 -: REG_W];
      default: bus_rdata = res_fmt[REG_W-1:0];
    endcase
  end

  // R2: control fields change only on a control write
  p_ctrl_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ctrl |=> ($stable(mode) && $stable(just) && $stable(ie)));
  // R8: right-justified high byte has zero padding on top
  p_right_pad_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (just && bus_addr == A_RHI) |-> (bus_rdata[REG_W-1 -: PAD_W] == '0));
  // R7: left-justified low byte has zero padding below
  p_left_pad_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!just && bus_addr == A_RLO) |-> (bus_rdata[PAD_W-1:0] == '0));
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int CODE_W = 12,
  parameter int REG_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [1:0]        bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  input  logic              tmr_ovf,
  input  logic              brg_ovf,
  output logic              conv_start,
  input  logic              conv_sampled,
  input  logic              conv_done,
  input  logic [CODE_W-1:0] conv_code,
  output logic              smp_irq
);
  trig_mode_e        mode;
  logic              just, ie, go, busy, launch, done_evt;
  logic              go_set_req, clr_done, clr_smp;
  logic [CODE_W-1:0] code_q;
  logic [N_FLAGS-1:0] flag_set, flag_clr, flag_q;

  adc_reg_if #(.CODE_W(CODE_W), .REG_W(REG_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .go(go), .busy(busy),
    .done_q(flag_q[F_DONE]), .smp_q(flag_q[F_SMP]), .code_q(code_q),
    .mode(mode), .just(just), .ie(ie), .go_set_req(go_set_req),
    .clr_done(clr_done), .clr_smp(clr_smp), .bus_rdata(bus_rdata)
  );

  adc_trig_sel u_trig (
    .mode(mode), .go(go), .tmr_ovf(tmr_ovf), .brg_ovf(brg_ovf),
    .busy(busy), .launch(launch)
  );

  adc_conv_fsm #(.CODE_W(CODE_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .launch(launch), .go_set_req(go_set_req),
    .conv_done(conv_done), .conv_code(conv_code), .busy(busy), .go(go),
    .code_q(code_q), .done_evt(done_evt)
  );

  assign flag_set[F_DONE] = done_evt;
  assign flag_clr[F_DONE] = clr_done;
  assign flag_set[F_SMP]  = conv_sampled && busy;
  assign flag_clr[F_SMP]  = clr_smp;

  generate
    for (genvar i = 0; i < N_FLAGS; i++) begin : g_flag
      adc_sticky_flag u_flag (
        .clk(clk), .rst_n(rst_n), .set(flag_set[i]), .clr(flag_clr[i]),
        .q(flag_q[i])
      );
    end
  endgenerate

  assign conv_start = launch;
  assign smp_irq    = flag_q[F_SMP] && ie;

  // R5: never start while a conversion is running
  p_no_start_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !conv_start);
  // R4: free-running restarts the cycle after completion
  p_free_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == TRIG_FREE && conv_done && busy && !(bus_wr && bus_addr == A_CTRL))
      |=> conv_start);
  // R11: interrupt only with its enable
  p_irq_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
    smp_irq |-> ie);
  // R9: the sample flag rises only from a sampled pulse during busy
  p_smp_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q[F_SMP]) |-> $past(conv_sampled && busy));
endmodule

// File: tb/sim_adc_seq_ctrl.sv
`timescale 1ns/1ps
module sim_adc_seq_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic tmr_ovf = 1'b0, brg_ovf = 1'b0;
  logic conv_start, smp_irq;
  logic conv_sampled = 1'b0, conv_done = 1'b0;
  logic [11:0] conv_code = 12'd0;

  int n_chk = 0, n_fail = 0, cyc = 0;
  string cur_req = "R1";

  // behavioural reference state
  int m_mode = 0;
  bit m_just = 0, m_ie = 0, m_go = 0, m_busy = 0, m_done = 0, m_smp = 0;
  int m_code = 0;

  adc_seq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tmr_ovf(tmr_ovf),
    .brg_ovf(brg_ovf), .conv_start(conv_start), .conv_sampled(conv_sampled),
    .conv_done(conv_done), .conv_code(conv_code), .smp_irq(smp_irq)
  );

  always #2.5 clk = ~clk;

  function automatic bit m_launch();
    bit r;
    case (m_mode)
      0: r = m_go;
      1: r = tmr_ovf;
      2: r = 1'b1;
      default: r = brg_ovf;
    endcase
    return r && !m_busy;
  endfunction

  function automatic int m_read(int a);
    int f;
    f = m_just ? m_code : (m_code << 4);
    case (a)
      0: return (int'(m_ie) << 4) | (int'(m_go) << 3) | (int'(m_just) << 2) | m_mode;
      1: return (int'(m_busy) << 2) | (int'(m_smp) << 1) | int'(m_done);
      2: return (f >> 8) & 8'hFF;
      default: return f & 8'hFF;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_just = 0; m_ie = 0; m_go = 0; m_busy = 0;
      m_done = 0; m_smp = 0; m_code = 0;
    end else begin
      bit l, ob;
      l = m_launch();
      ob = m_busy;
      if (bus_wr && bus_addr == 2'd0) begin
        m_mode = int'(bus_wdata[1:0]); m_just = bus_wdata[2]; m_ie = bus_wdata[4];
        if (bus_wdata[3] && !ob) m_go = 1;
      end
      if (bus_wr && bus_addr == 2'd1) begin
        if (!bus_wdata[0]) m_done = 0;
        if (!bus_wdata[1]) m_smp = 0;
      end
      if (l) m_busy = 1;
      if (conv_done && ob) begin
        m_busy = 0; m_code = int'(conv_code); m_done = 1; m_go = 0;
      end
      if (conv_sampled && ob) m_smp = 1;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: req %s act=%0d exp=%0d", cur_req, cyc, 20000);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: act=0x%0h exp=0x%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic expect_eq(string req, int act, int exp);
    check(act == exp, req, act, exp);
  endtask

  // one cycle: drive inputs after the falling edge, then compare with the model
  task automatic slot(bit w, int a, int d, bit t, bit b, bit s, bit dn, int code);
    @(negedge clk);
    bus_wr = w; bus_addr = 2'(a); bus_wdata = 8'(d);
    tmr_ovf = t; brg_ovf = b; conv_sampled = s; conv_done = dn;
    conv_code = 12'(code);
    #1;
    check(conv_start === m_launch(), {cur_req, " start"}, int'(conv_start), int'(m_launch()));
    check(smp_irq === (m_smp && m_ie), {cur_req, " irq"}, int'(smp_irq), int'(m_smp && m_ie));
    check(int'(bus_rdata) == m_read(a), {cur_req, " rdata"}, int'(bus_rdata), m_read(a));
  endtask

  task automatic idle(int a);
    slot(0, a, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic wr(int a, int d);
    slot(1, a, d, 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    cur_req = "R1";
    for (int a = 0; a < 4; a++) begin
      idle(a);
      expect_eq("R1", int'(bus_rdata), 0);
    end
    expect_eq("R1", int'(conv_start), 0);
    expect_eq("R1", int'(smp_irq), 0);

    // R2 software start, R7 left justify, R6 completion
    cur_req = "R2";
    wr(0, 8'h08);
    idle(0);
    expect_eq("R2", int'(conv_start), 1);
    expect_eq("R2", int'(bus_rdata), 8'h08);
    idle(1);
    expect_eq("R2", int'(conv_start), 0);
    expect_eq("R6", int'(bus_rdata), 8'h04);
    slot(0, 1, 0, 0, 0, 1, 0, 0);
    slot(0, 1, 0, 0, 0, 0, 1, 12'hFFF);
    cur_req = "R6";
    idle(1);
    expect_eq("R6", int'(bus_rdata), 8'h03);
    idle(0);
    expect_eq("R2", int'(bus_rdata), 8'h00);
    cur_req = "R7";
    idle(2); expect_eq("R7", int'(bus_rdata), 8'hFF);
    idle(3); expect_eq("R7", int'(bus_rdata), 8'hF0);

    // R8 right justify, applied on read, then mid-scale
    cur_req = "R8";
    wr(0, 8'h04);
    idle(2); expect_eq("R8", int'(bus_rdata), 8'h0F);
    idle(3); expect_eq("R8", int'(bus_rdata), 8'hFF);
    wr(0, 8'h0C);
    idle(0);
    slot(0, 1, 0, 0, 0, 0, 1, 12'h800);
    idle(2); expect_eq("R8", int'(bus_rdata), 8'h08);
    idle(3); expect_eq("R8", int'(bus_rdata), 8'h00);

    // R12 clear done, R9 write of 1 keeps sample flag
    cur_req = "R12";
    wr(1, 8'h02);
    idle(1);
    expect_eq("R12", int'(bus_rdata), 8'h02);
    expect_eq("R9", int'(bus_rdata[1]), 1);

    // R11 interrupt gating
    cur_req = "R11";
    expect_eq("R11", int'(smp_irq), 0);
    wr(0, 8'h10);
    idle(1);
    expect_eq("R11", int'(smp_irq), 1);
    cur_req = "R9";
    wr(1, 8'h00);
    idle(1);
    expect_eq("R9", int'(bus_rdata), 8'h00);
    expect_eq("R11", int'(smp_irq), 0);

    // R3 timer trigger, R5 triggers ignored while busy
    cur_req = "R3";
    wr(0, 8'h11);
    slot(0, 1, 0, 0, 1, 0, 0, 0);
    expect_eq("R3", int'(conv_start), 0);
    slot(0, 1, 0, 1, 0, 0, 0, 0);
    expect_eq("R3", int'(conv_start), 1);
    cur_req = "R5";
    slot(0, 1, 0, 1, 0, 0, 0, 0);
    expect_eq("R5", int'(conv_start), 0);
    slot(0, 1, 0, 0, 1, 0, 0, 0);
    expect_eq("R5", int'(conv_start), 0);
    wr(0, 8'h19);
    idle(0);
    expect_eq("R5", int'(bus_rdata), 8'h11);
    slot(0, 1, 0, 0, 0, 0, 1, 12'h123);

    // R3 baud trigger
    cur_req = "R3";
    wr(0, 8'h13);
    slot(0, 1, 0, 1, 0, 0, 0, 0);
    expect_eq("R3", int'(conv_start), 0);
    slot(0, 1, 0, 0, 1, 0, 0, 0);
    expect_eq("R3", int'(conv_start), 1);

    // R10 set beats clear on both flags
    cur_req = "R10";
    slot(1, 1, 8'h00, 0, 0, 1, 0, 0);
    idle(1);
    expect_eq("R10", int'(bus_rdata), 8'h06);
    expect_eq("R11", int'(smp_irq), 1);
    slot(1, 1, 8'h00, 0, 0, 0, 1, 12'h456);
    idle(1);
    expect_eq("R10", int'(bus_rdata), 8'h01);

    // R6 done while idle is ignored
    cur_req = "R6";
    slot(0, 2, 0, 0, 0, 0, 1, 12'hABC);
    idle(2); expect_eq("R6", int'(bus_rdata), 8'h45);
    idle(3); expect_eq("R6", int'(bus_rdata), 8'h60);

    // R4 free-running
    cur_req = "R4";
    wr(0, 8'h02);
    for (int k = 0; k < 3; k++) begin
      idle(1);
      expect_eq("R4", int'(conv_start), 1);
      idle(1);
      expect_eq("R4", int'(conv_start), 0);
      slot(0, 1, 0, 0, 0, 0, 1, k * 12'h111 + 1);
    end
    idle(1);
    expect_eq("R4", int'(conv_start), 1);
    idle(1);
    slot(1, 0, 8'h00, 0, 0, 0, 1, 12'h9A5);
    idle(1);
    expect_eq("R4", int'(conv_start), 0);
    idle(2); expect_eq("R4", int'(bus_rdata), 8'h9A);
    idle(3); expect_eq("R4", int'(bus_rdata), 8'h50);
    repeat (3) idle(0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule